// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Queue

This block is the receive half of an asynchronous serial port. A bit-rate divider elsewhere supplies a tick at sixteen times the bit rate. The block watches the serial input on those ticks, checks each start bit at its midpoint, and shifts in the data bits, least significant first. Each frame carries 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. The assembled character goes into a 16-deep first-in first-out queue, and each entry keeps its own parity-error and framing-error flags.

The queue head is always visible at the read port. A one-cycle read strobe removes it. The block raises three separate request lines: one for a full queue, which can also start a DMA transfer; one for a receive error; and one for a break on the line. A request-to-send output with hysteresis tells the far transmitter to pause before the queue overflows. If a character arrives while the queue is full, it is dropped and a sticky overrun flag is set.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty (`fifo_count` = 0, `fifo_empty` = 1), `rts` is 1, and `rx_full_req`, `irq_err`, `irq_brk` and `ovr_flag` are 0.
- R2: A falling edge only counts as a start bit if the line is still low at the eighth tick after detection. A low pulse that ends before then stores no character.
- R3: In 8-bit mode a frame is received least significant bit first and appended to the queue with `fifo_count` incremented.
- R4: When `cfg_data7` = 1, seven data bits are received and bit 7 of the stored character is 0.
- R5: When `cfg_par_en` = 1, `rd_perr` for a character is 1 exactly when its data bits plus its parity bit hold an odd number of ones (`cfg_par_odd` = 0) or an even number of ones (`cfg_par_odd` = 1).
- R6: `rd_ferr` is 1 when the first stop bit samples low. A low second stop bit in two-stop mode is not an error. After a stop position samples low, the receiver waits for the line to go high before it looks for a new start bit.
- R7: When every data, parity and first-stop position samples low, no character is stored and `irq_brk` goes high. It stays high until the line returns high, and the next frame after that is received normally.
- R8: The queue holds 16 characters and returns them in arrival order. `rx_full_req` is 1 exactly when it holds 16.
- R9: A character that completes while the queue is full is discarded and sets `ovr_flag`. The flag stays set until `ovr_clr` is pulsed.
- R10: `irq_err` is 1 while the head entry carries a parity or framing error, or while `ovr_flag` is set.
- R11: `rts` falls when `fifo_count` reaches 14, stays low while the count is above 8, and rises once the count is 8 or less.
- R12: Error flags belong to their own character: popping an errored entry shows the next entry's own flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_16x | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial data input, idle high |
| cfg_data7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rd_en | input | 1 | Pop the head entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| fifo_empty | output | 1 | Queue empty |
| fifo_count | output | 5 | Entries held |
| rx_full_req | output | 1 | Queue-full interrupt and DMA request |
| irq_err | output | 1 | Receive-error request |
| irq_brk | output | 1 | Break request |
| ovr_flag | output | 1 | Sticky overrun |
| rts | output | 1 | Request to send, 1 = send allowed |

## Verification
A character is sampled on the tick at the middle of its last stop bit. One clock later it sits in the push register, and one clock after that it shows in `fifo_count` and at the read port. `rts` follows `fifo_count` one clock later still, and `irq_brk` rises one clock after the first stop-bit tick of an all-low frame. The bench therefore checks each frame only after its full stop period and one more idle-high bit, which leaves tens of clocks of margin. It checks `rts` two clocks after each pop, and holds each read strobe for exactly one clock between falling edges.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH   = 16,
  parameter int OSR     = 16,
  parameter int RTS_OFF = 14,
  parameter int RTS_ON  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rxd,
  input  logic       cfg_data7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       rd_en,
  input  logic       ovr_clr,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       fifo_empty,
  output logic [4:0] fifo_count,
  output logic       rx_full_req,
  output logic       irq_err,
  output logic       irq_brk,
  output logic       ovr_flag,
  output logic       rts
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [AW:0]   FULLV = (AW+1)'(DEPTH);
  localparam logic [AW:0]   OFFV  = (AW+1)'(RTS_OFF);
  localparam logic [AW:0]   ONV   = (AW+1)'(RTS_ON);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          pbit, all_low, f1;
  logic          push_q, push_perr, push_ferr;
  logic [7:0]    push_data;

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  wire [7:0] dat    = cfg_data7 ? {1'b0, sh[7:1]} : sh;
  wire       perr_c = cfg_par_en & (^dat ^ pbit ^ cfg_par_odd);
  wire       full   = (count == FULLV);
  wire       do_push = push_q & ~full;
  wire       do_pop  = rd_en & (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; sh <= '0;
      pbit <= 1'b0; all_low <= 1'b0; f1 <= 1'b0; irq_brk <= 1'b0;
      push_q <= 1'b0; push_perr <= 1'b0; push_ferr <= 1'b0; push_data <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick_16x) begin
        case (st)
          S_IDLE: if (!rxd) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == MID) begin
              cnt <= '0; nbit <= '0; all_low <= 1'b1; pbit <= 1'b0;
              st <= rxd ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_WAIT: if (rxd) begin st <= S_IDLE; irq_brk <= 1'b0; end
          default:
            if (cnt != LAST) cnt <= cnt + 1'b1;
            else begin
              cnt <= '0;
              case (st)
                S_DATA: begin
                  sh <= {rxd, sh[7:1]};
                  all_low <= all_low & ~rxd;
                  nbit <= nbit + 1'b1;
                  if (nbit == (cfg_data7 ? 3'd6 : 3'd7)) st <= cfg_par_en ? S_PAR : S_STOP1;
                end
                S_PAR: begin
                  pbit <= rxd; all_low <= all_low & ~rxd; st <= S_STOP1;
                end
                S_STOP1: begin
                  f1 <= ~rxd;
                  if (!rxd && all_low) begin
                    st <= S_WAIT; irq_brk <= 1'b1;
                  end else if (cfg_stop2) st <= S_STOP2;
                  else begin
                    push_q <= 1'b1; push_data <= dat; push_perr <= perr_c; push_ferr <= ~rxd;
                    st <= rxd ? S_IDLE : S_WAIT;
                  end
                end
                default: begin
                  push_q <= 1'b1; push_data <= dat; push_perr <= perr_c; push_ferr <= f1;
                  st <= rxd ? S_IDLE : S_WAIT;
                end
              endcase
            end
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= {push_ferr, push_perr, push_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; ovr_flag <= 1'b0; rts <= 1'b1;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
      if (push_q && full) ovr_flag <= 1'b1;
      else if (ovr_clr)   ovr_flag <= 1'b0;
      if (count >= OFFV)     rts <= 1'b0;
      else if (count <= ONV) rts <= 1'b1;
    end
  end

  wire [9:0] head = mem[rptr];
  assign rd_data     = head[7:0];
  assign rd_perr     = head[8];
  assign rd_ferr     = head[9];
  assign fifo_empty  = (count == '0);
  assign fifo_count  = 5'(count);
  assign rx_full_req = full;
  assign irq_err     = ovr_flag | (~fifo_empty & (head[8] | head[9]));
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH   = 16,
  parameter int RTS_OFF = 14,
  parameter int RTS_ON  = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] fifo_count,
  input logic       fifo_empty,
  input logic       rx_full_req,
  input logic       rts,
  input logic       ovr_flag,
  input logic       ovr_clr,
  input logic       irq_brk
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(fifo_count) <= DEPTH); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_count) <= int'($past(fifo_count)) + 1) && (int'(fifo_count) + 1 >= int'($past(fifo_count)))); // R8
  AST_FULL_REQ: assert property (@(posedge clk) disable iff (!rst_n) rx_full_req |-> !fifo_empty); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovr_flag && !ovr_clr) |=> ovr_flag); // R9
  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (int'(fifo_count) >= RTS_OFF) |=> !rts); // R11
  AST_RTS_ON: assert property (@(posedge clk) disable iff (!rst_n) (int'(fifo_count) <= RTS_ON) |=> rts); // R11
  AST_BRK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_brk) |-> fifo_count <= $past(fifo_count)); // R7
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .RTS_OFF(RTS_OFF), .RTS_ON(RTS_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
  .rx_full_req(rx_full_req), .rts(rts), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .irq_brk(irq_brk)
);

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  logic clk = 1'b0, rst_n = 1'b0, tick_16x = 1'b0, rxd = 1'b1;
  logic cfg_data7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, fifo_empty, rx_full_req, irq_err, irq_brk, ovr_flag, rts;
  logic [4:0] fifo_count;
  logic [1:0] div = '0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    div <= div + 1'b1;
    tick_16x <= (div == 2'd3);
  end

  uart_rx_fifo i_uart_rx_fifo (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit s1, input bit s2);
    logic [7:0] m;
    m = cfg_data7 ? (d & 8'h7f) : d;
    bit_out(1'b0);
    for (int i = 0; i < (cfg_data7 ? 7 : 8); i++) bit_out(m[i]);
    if (cfg_par_en) bit_out(^m ^ cfg_par_odd ^ bad_par);
    bit_out(s1);
    if (cfg_stop2) bit_out(s2);
    bit_out(1'b1);
  endtask

  task automatic pop(input string req, input logic [7:0] d, input logic pe, input logic fe);
    check(req, {22'd0, rd_ferr, rd_perr, rd_data}, {22'd0, fe, pe, d});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", fifo_count, 0);
    check("R1 flags", {fifo_empty, rts, rx_full_req, irq_err, irq_brk, ovr_flag}, 6'b110000);
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (192) @(negedge clk);
    check("R2 glitch ignored", {fifo_empty, fifo_count}, {1'b1, 5'd0});
  endtask

  task automatic t_basic;
    send(8'hA5, 0, 1, 1);
    send(8'h3C, 0, 1, 1);
    check("R3 count", fifo_count, 2);
    pop("R3 first", 8'hA5, 0, 0);
    pop("R3 second", 8'h3C, 0, 0);
    check("R3 empty", fifo_empty, 1);
  endtask

  task automatic t_seven;
    cfg_data7 = 1'b1;
    send(8'hC3, 0, 1, 1);
    cfg_par_en = 1'b1;
    send(8'h55, 0, 1, 1);
    pop("R4 seven bit", 8'h43, 0, 0);
    pop("R4 seven bit even parity", 8'h55, 0, 0);
    cfg_data7 = 1'b0; cfg_par_en = 1'b0;
  endtask

  task automatic t_parity;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h35, 0, 1, 1);
    send(8'h35, 1, 1, 1);
    cfg_par_odd = 1'b1;
    send(8'h0F, 0, 1, 1);
    send(8'h0F, 1, 1, 1);
    check("R10 clean head", irq_err, 0);
    pop("R5 even good", 8'h35, 0, 0);
    check("R10 perr head", irq_err, 1);
    pop("R5 even bad", 8'h35, 1, 0);
    pop("R12 odd good after bad", 8'h0F, 0, 0);
    pop("R5 odd bad", 8'h0F, 1, 0);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
  endtask

  task automatic t_frame;
    send(8'h81, 0, 0, 1);
    check("R10 ferr head", irq_err, 1);
    cfg_stop2 = 1'b1;
    send(8'h18, 0, 1, 0);
    send(8'h18, 0, 0, 1);
    pop("R6 stop low", 8'h81, 0, 1);
    pop("R6 second stop low ok", 8'h18, 0, 0);
    pop("R6 two stop first low", 8'h18, 0, 1);
    cfg_stop2 = 1'b0;
  endtask

  task automatic t_break;
    rxd = 1'b0;
    repeat (12 * 64) @(negedge clk);
    check("R7 break raised", {irq_brk, fifo_count}, {1'b1, 5'd0});
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    check("R7 break released", irq_brk, 0);
    send(8'h5A, 0, 1, 1);
    pop("R7 after break", 8'h5A, 0, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 7 + 1), 0, 1, 1);
      if (i == 12) check("R11 rts at 13", rts, 1);
      if (i == 13) check("R11 rts drop at 14", rts, 0);
      if (i == 14) check("R8 not full at 15", rx_full_req, 0);
    end
    check("R8 full", {rx_full_req, fifo_count}, {1'b1, 5'd16});
    send(8'hEE, 0, 1, 1);
    check("R9 overrun", {ovr_flag, fifo_count}, {1'b1, 5'd16});
    check("R10 overrun err", irq_err, 1);
    for (int i = 0; i < 16; i++) begin
      pop("R8 order", 8'(i * 7 + 1), 0, 0);
      @(negedge clk);
      if (i == 6) check("R11 rts low at 9", rts, 0);
      if (i == 7) check("R11 rts back at 8", rts, 1);
    end
    check("R9 sticky after drain", ovr_flag, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
    check("R9 cleared", {ovr_flag, irq_err, fifo_empty}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_glitch;
    t_basic;
    t_seven;
    t_parity;
    t_frame;
    t_break;
    t_fill;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule